// File: doc/BRIEF.md
# Self-Timed Page Program Cycle Controller

This block sits beside a two-wire serial memory's protocol engine and owns the internally timed programming cycle. When the protocol engine reports a stop condition that ends a write transaction, the controller takes a snapshot of the page buffer: the byte contents, a per-slot "received" flag, and the page row. It then writes the received slots into the storage array, one per clock, and holds a busy flag for a fixed programming time counted in system clocks.

While busy, the controller tells the protocol engine to treat the bus as dead. Any start plus matching device address is refused its acknowledge, whether the master asks to read or to write. This gives the master acknowledge polling: it keeps sending the device address until it sees the acknowledge. A stop that closes a transaction with no data byte received, such as a stop after only the word address, leaves the array untouched and starts no cycle.

Top module: `wrcyc_ctrl`

## Requirements
- R1: After reset, `busy`, `arr_we` and `addr_ack` are all low.
- R2: A `commit_req` sampled while idle with at least one bit of `buf_be` set makes `busy` go high on the next clock. `busy` then stays high for exactly `TWR_CYCLES` clock cycles.
- R3: A `commit_req` sampled with `buf_be` all zero starts no cycle: `busy` stays low and no array write occurs.
- R4: Enabled slots are written one per cycle, in ascending slot order, during the first `PAGE_BYTES` busy cycles. Slot i is written to `{page_base[ADDR_W-1:log2(PAGE_BYTES)], i}`, so the low bits of `page_base` are ignored. The data is byte i of `buf_data`, at bits `[8i+7:8i]`.
- R5: A slot whose `buf_be` bit was zero at commit produces no array write.
- R6: While `busy` is high, `addr_ack` stays low even when `dev_addr_hit` is asserted.
- R7: While `busy` is low, `addr_ack` follows `dev_addr_hit` in the same cycle.
- R8: A `commit_req` arriving while busy is ignored. The busy window keeps its original length, and no extra array writes occur.
- R9: Data, enables and page row are captured at commit. Later changes on `buf_data`, `buf_be` or `page_base` do not alter the writes of the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| commit_req | input | 1 | Pulse: stop condition closed a write transaction |
| page_base | input | ADDR_W | Word address of the transaction; upper bits select the page row |
| buf_data | input | PAGE_BYTES*8 | Page buffer contents, slot i at bits [8i+7:8i] |
| buf_be | input | PAGE_BYTES | Per-slot flag: slot received a data byte |
| dev_addr_hit | input | 1 | Pulse: protocol engine decoded a matching device address (either R/W) |
| addr_ack | output | 1 | Grant to drive the acknowledge for that device address |
| busy | output | 1 | Programming cycle in progress; bus inputs are to be ignored |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The assertions assume `TWR_CYCLES` is at least `PAGE_BYTES`, so the array scan always ends inside the busy window. They also assume `commit_req` and `dev_addr_hit` are single-cycle strobes sampled on the clock. The stimulus drives every input on the falling edge and never widens a strobe beyond one cycle, except where a commit is deliberately held inside a busy window to probe R8. The page buffer is changed only between commits or during busy, which is exactly the case R9 addresses.

// File: rtl/wrcyc_pkg.sv
// Package wrcyc_pkg
// Shared types for the programming cycle controller.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package wrcyc_pkg;

    // State of the array scan that commits buffered bytes.
    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_st_e;

    // Width of one data byte on the array port.
    localparam int BYTE_W = 8;

endpackage

// File: rtl/wrcyc_timer.sv
// Module wrcyc_timer
// Down counter that times the programming cycle. On load it raises
// busy and holds it for exactly TWR_CYCLES clocks.
// Assumes load is never asserted while busy (the parent gates it).
module wrcyc_timer #(
    parameter int TWR_CYCLES = 40,
    localparam int CNT_W = $clog2(TWR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);

    logic [CNT_W-1:0] cnt_q;

    // Load, count down, and drop busy after the last counted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            busy  <= 1'b0;
        end else if (load) begin
            cnt_q <= CNT_W'(TWR_CYCLES - 1);
            busy  <= 1'b1;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R2: while busy, the count steps down by one every cycle.
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(load)) |-> (cnt_q == $past(cnt_q) - 1'b1));

    // R2: the count never exceeds the programmed window.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= CNT_W'(TWR_CYCLES - 1)));

endmodule

// File: rtl/wrcyc_scan.sv
// Module wrcyc_scan
// Captures the page buffer at start, then walks the slots in
// ascending order, one per clock, and strobes the array for every
// slot that was flagged as received.
// Assumes start is only pulsed while the scan is idle.
module wrcyc_scan
    import wrcyc_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int ADDR_W     = 8,
    localparam int IDX_W = $clog2(PAGE_BYTES),
    localparam int ROW_W = ADDR_W - IDX_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [ADDR_W-1:0]          page_base,
    input  logic [PAGE_BYTES*BYTE_W-1:0] buf_data,
    input  logic [PAGE_BYTES-1:0]      buf_be,
    output logic                       arr_we,
    output logic [ADDR_W-1:0]          arr_addr,
    output logic [BYTE_W-1:0]          arr_wdata
);

    scan_st_e                   st_q;
    logic [IDX_W-1:0]           idx_q;
    logic [ROW_W-1:0]           row_q;
    logic [PAGE_BYTES-1:0]      be_q;
    logic [BYTE_W-1:0]          slot_q [PAGE_BYTES];

    // Snapshot every buffered byte at start so later buffer edits cannot leak in.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (start) begin
                slot_q[g] <= buf_data[g*BYTE_W +: BYTE_W];
            end
        end
    end

    // Sequence the scan pointer across the page and return to idle at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SCAN_IDLE;
            idx_q <= '0;
            row_q <= '0;
            be_q  <= '0;
        end else if (start) begin
            st_q  <= SCAN_RUN;
            idx_q <= '0;
            row_q <= page_base[ADDR_W-1:IDX_W];
            be_q  <= buf_be;
        end else if (st_q == SCAN_RUN) begin
            if (idx_q == IDX_W'(PAGE_BYTES - 1)) begin
                st_q <= SCAN_IDLE;
            end
            idx_q <= idx_q + 1'b1;
        end
    end

    // Drive the array port from the captured slot under the pointer.
    always_comb begin
        arr_we    = (st_q == SCAN_RUN) && be_q[idx_q];
        arr_addr  = {row_q, idx_q};
        arr_wdata = slot_q[idx_q];
    end

    // R4: the page row on the array port is frozen for the whole scan.
    a_r4_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SCAN_RUN && $past(st_q == SCAN_RUN) && !$past(start))
            |-> $stable(arr_addr[ADDR_W-1:IDX_W]));

    // R4: slots are visited in strictly ascending order.
    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SCAN_RUN && $past(st_q == SCAN_RUN) && !$past(start))
            |-> (idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/wrcyc_ctrl.sv
// Module wrcyc_ctrl
// Top of the self-timed programming cycle. Accepts a commit from the
// protocol engine, writes the received page slots to the array, and
// holds busy for TWR_CYCLES clocks, refusing every device-address
// acknowledge meanwhile so the master can poll.
// Assumes TWR_CYCLES >= PAGE_BYTES and single-cycle input strobes.
module wrcyc_ctrl
    import wrcyc_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int ADDR_W     = 8,
    parameter int TWR_CYCLES = 40
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         commit_req,
    input  logic [ADDR_W-1:0]            page_base,
    input  logic [PAGE_BYTES*BYTE_W-1:0] buf_data,
    input  logic [PAGE_BYTES-1:0]        buf_be,
    input  logic                         dev_addr_hit,
    output logic                         addr_ack,
    output logic                         busy,
    output logic                         arr_we,
    output logic [ADDR_W-1:0]            arr_addr,
    output logic [BYTE_W-1:0]            arr_wdata
);

    logic commit_go;

    // Start a cycle only from idle and only if some data byte arrived.
    always_comb begin
        commit_go = commit_req && (|buf_be) && !busy;
        addr_ack  = dev_addr_hit && !busy;
    end

    wrcyc_timer #(
        .TWR_CYCLES (TWR_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (commit_go),
        .busy  (busy)
    );

    wrcyc_scan #(
        .PAGE_BYTES (PAGE_BYTES),
        .ADDR_W     (ADDR_W)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (commit_go),
        .page_base (page_base),
        .buf_data  (buf_data),
        .buf_be    (buf_be),
        .arr_we    (arr_we),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata)
    );

    // R2: the programming window must cover the whole page scan.
    initial begin
        a_r2_window_covers_scan: assert (TWR_CYCLES >= PAGE_BYTES);
    end

    // R2: a valid commit from idle raises busy on the next clock.
    a_r2_busy_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && (|buf_be) && !busy) |=> busy);

    // R3: busy only ever rises after a commit that carried data.
    a_r3_rise_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit_req && (|buf_be)));

    // R4: the scan never writes the array outside the busy window.
    a_r4_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R6: a device-address hit in the busy window is never acknowledged.
    a_r6_refuse_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dev_addr_hit) |-> !addr_ack);

endmodule

// File: tb/wrcyc_ctrl_bench.sv
// Bench for wrcyc_ctrl: a driver pushes expected array writes into a
// queue, a monitor pops and compares them as the array port strobes.
module wrcyc_ctrl_bench;

    localparam int PB   = 8;
    localparam int AW   = 8;
    localparam int TWR  = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            commit_req = 1'b0;
    logic [AW-1:0]   page_base = '0;
    logic [PB*8-1:0] buf_data = '0;
    logic [PB-1:0]   buf_be = '0;
    logic            dev_addr_hit = 1'b0;
    logic            addr_ack;
    logic            busy;
    logic            arr_we;
    logic [AW-1:0]   arr_addr;
    logic [7:0]      arr_wdata;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] exp_q [$];

    always #4 clk = ~clk;

    wrcyc_ctrl #(.PAGE_BYTES(PB), .ADDR_W(AW), .TWR_CYCLES(TWR)) u_wrcyc_ctrl (
        .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .page_base(page_base),
        .buf_data(buf_data), .buf_be(buf_be), .dev_addr_hit(dev_addr_hit),
        .addr_ack(addr_ack), .busy(busy), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // Monitor: every array strobe must match the head of the expectation queue.
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected write", {arr_addr, arr_wdata}, 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk({arr_addr, arr_wdata} == e, "R4 write addr/data", {arr_addr, arr_wdata}, e);
            end
        end
    end

    // Driver: commit a page, count the busy window, optionally disturb it.
    task automatic run_commit(input logic [AW-1:0] base, input logic [PB*8-1:0] data,
                              input logic [PB-1:0] be, input bit disturb);
        int n;
        @(negedge clk);
        page_base = base; buf_data = data; buf_be = be; commit_req = 1'b1;
        for (int i = 0; i < PB; i++) begin
            if (be[i]) exp_q.push_back({base[AW-1:3], 3'(i), data[i*8 +: 8]});
        end
        @(negedge clk);
        commit_req = 1'b0;
        n = 0;
        while (busy && n < 1000) begin
            if (disturb && n == 2) begin
                // R8/R9: new commit with altered buffer while busy; R6: poll.
                commit_req = 1'b1; buf_data = ~data; buf_be = '1;
                page_base = base ^ 8'h40; dev_addr_hit = 1'b1;
                #1;
                chk(addr_ack == 1'b0, "R6 ack refused while busy", addr_ack, 0);
            end
            if (disturb && n == 3) begin
                commit_req = 1'b0; dev_addr_hit = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        if (be != '0) begin
            chk(n == TWR, disturb ? "R8 busy window length" : "R2 busy window length", n, TWR);
        end else begin
            for (int k = 0; k < 5; k++) begin
                chk(busy == 1'b0, "R3 no cycle without data", busy, 0);
                @(negedge clk);
            end
        end
        chk(exp_q.size() == 0, "R4/R5 all expected writes seen", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy at reset", busy, 0);
        chk(arr_we == 1'b0, "R1 we at reset", arr_we, 0);
        chk(addr_ack == 1'b0, "R1 ack at reset", addr_ack, 0);
        rst_n = 1'b1;
        @(negedge clk);
        dev_addr_hit = 1'b1; #1;
        chk(addr_ack == 1'b1, "R7 ack when idle", addr_ack, 1);
        @(negedge clk);
        dev_addr_hit = 1'b0;
        run_commit(8'h28, 64'h8877665544332211, 8'hFF, 1'b0);
        run_commit(8'h93, 64'hF0E0D0C0B0A09080, 8'hA5, 1'b0);
        run_commit(8'h50, 64'h0102030405060708, 8'h00, 1'b0);
        run_commit(8'h07, 64'hDEADBEEFCAFEF00D, 8'h3C, 1'b1);
        run_commit(8'hF8, 64'h1111111111111111, 8'h80, 1'b0);
        @(negedge clk);
        dev_addr_hit = 1'b1; #1;
        chk(addr_ack == 1'b1, "R7 ack after cycle ends", addr_ack, 1);
        @(negedge clk);
        dev_addr_hit = 1'b0;
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule